// File: doc/BRIEF.md
# Pixel Offset and Gain Correction Pipeline

This block is the digital back end of an image-sensor front end. Every ADC clock it receives one digitized sample. It works out which colour channel and which odd/even pixel set the sample belongs to. It then corrects the sample in three steps, in this order:

1. It adds a programmable signed offset chosen by colour and parity.
2. It subtracts a per-pixel value taken from an offset bus.
3. It multiplies by a per-pixel fixed-point value taken from a gain bus.

Each corrected word leaves the block with a valid flag and a colour tag aligned to it.

The block has two modes. In three-channel mode the colour steps through red, green and blue. In one-channel mode a configuration field fixes the colour. A line-start input held low resynchronizes the colour and parity sequencing. The offset bus and gain bus values lead their pixel by more clock cycles than the sample does. The block delays them internally so that they meet the sample they belong to. Offsets and configuration are written through a small address/data/write-enable port. The sample width is a parameter and defaults to 12 bits (10 is the narrow variant).

Top module: `pix_corr_top`

## Requirements
- R1: `line_go` is sampled on each rising clock edge. When it is low, that edge returns the colour sequence to red and the parity to even, and the sample taken at that edge produces no output. While `pix_vld` is low, `pix_out` reads 0.
- R2: In three-channel mode, valid outputs are tagged in the order red, green, blue, repeating. The tags are red=0, green=1 and blue=2, and the first valid pixel after `line_go` rises is red.
- R3: The first pixel set of a line is even, and the sets then alternate even and odd. A set is one red-green-blue triple in three-channel mode and one pixel in one-channel mode. The signed offset applied is the one at register address colour*2+parity, with odd=1, so addresses 0 to 5 hold red-even, red-odd, green-even, green-odd, blue-even and blue-odd.
- R4: Address 6 is the configuration register. Bit 0 set selects three-channel mode. Bits 7:6 pick the fixed colour for one-channel mode: 0 is red, 1 is green, and both 2 and 3 mean blue. In one-channel mode every valid output carries that colour.
- R5: The first intermediate value is the sample plus the signed 8-bit register offset, clamped to the range 0 to 2^DATA_W-1. The unsigned 8-bit `ofs_bus` value is then subtracted from it, and a negative result is clamped to 0.
- R6: The value from R5 is multiplied by the unsigned 8-bit `gain_bus`, where 128 means unity gain. The output is (product+64)>>7, saturated at 2^DATA_W-1.
- R7: A sample driven in clock cycle t appears on `pix_out`, `pix_vld` and `pix_col` in cycle t+6, in both modes.
- R8: The `ofs_bus` and `gain_bus` values for a pixel are driven 3 cycles before its sample in three-channel mode (9 before its output). In one-channel mode they are driven 1 cycle before its sample (7 before its output).
- R9: A write to address 7 changes no offset and no configuration.
- R10: A synchronous reset clears all six offsets to 0, sets the configuration to 0x01 (three-channel mode) and drives `pix_vld` and `pix_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| line_go | input | 1 | Line-start; low resynchronizes sequencing |
| sample_in | input | DATA_W | Digitized sample |
| ofs_bus | input | 8 | Per-pixel value to subtract |
| gain_bus | input | 8 | Per-pixel gain, 128 = 1.0 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pix_out | output | DATA_W | Corrected pixel |
| pix_vld | output | 1 | Output word valid |
| pix_col | output | 2 | Colour tag of the output word |

## Verification
The bench drops `line_go` for a single cycle in the middle of a red-green-blue triple. A design that resumed the colour count there, or kept the parity, would tag the next pixel green or blue, or would apply the odd-set offset to it. The samples include full-scale values, zero values, the most negative and most positive register offsets, zero gain and maximum gain, so a design with a missing clamp would wrap instead of saturating. The bench switches between modes and checks every output against both bus leads. A design with a bus delay that is one cycle off, or that uses the three-channel delay in one-channel mode, would pair every pixel with its neighbour's offset and gain. A final write to the unused address catches a design that decodes that address onto the configuration or an offset register.

// File: rtl/pix_corr_pkg.sv
package pix_corr_pkg;

    typedef enum logic [1:0] {
        COL_R = 2'd0,
        COL_G = 2'd1,
        COL_B = 2'd2
    } colour_e;

    typedef struct packed {
        logic    vld;
        colour_e col;
    } ptag_t;

    localparam int ADDR_W    = 3;
    localparam int REG_W     = 8;
    localparam int BUS_W     = 8;
    localparam int OFS_REGS  = 6;
    localparam int ADDR_CFG  = 6;
    localparam int PIPE_LAT  = 6;
    localparam int LEAD_TRI  = 9;
    localparam int LEAD_MONO = 7;
    localparam int RND_SH    = 7;
    localparam logic [7:0] CFG_RST = 8'h01;

    // Cycle at which each bus value is consumed, counted from its capture.
    localparam int OFS_TAP_TRI   = LEAD_TRI  - PIPE_LAT + 1;
    localparam int OFS_TAP_MONO  = LEAD_MONO - PIPE_LAT + 1;
    localparam int GAIN_TAP_TRI  = LEAD_TRI  - PIPE_LAT + 2;
    localparam int GAIN_TAP_MONO = LEAD_MONO - PIPE_LAT + 2;

    function automatic colour_e col_after(colour_e c);
        case (c)
            COL_R:   return COL_G;
            COL_G:   return COL_B;
            default: return COL_R;
        endcase
    endfunction

    function automatic colour_e col_from_field(logic [1:0] f);
        return (f == 2'd3) ? COL_B : colour_e'(f);
    endfunction

endpackage

// File: rtl/pix_corr_regs.sv
module pix_corr_regs
    import pix_corr_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [REG_W-1:0]                 wr_data,
    output logic [OFS_REGS-1:0][REG_W-1:0]   ofs_tbl,
    output logic                             tri_mode,
    output colour_e                          mono_col
);

    logic       tri_q;
    logic [1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_tbl <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < OFS_REGS; k++) begin
                if (wr_addr == ADDR_W'(k)) ofs_tbl[k] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tri_q <= CFG_RST[0];
            sel_q <= CFG_RST[7:6];
        end else if (wr_en && wr_addr == ADDR_W'(ADDR_CFG)) begin
            tri_q <= wr_data[0];
            sel_q <= wr_data[7:6];
        end
    end

    assign tri_mode = tri_q;
    assign mono_col = col_from_field(sel_q);

endmodule

// File: rtl/pix_corr_seq.sv
module pix_corr_seq
    import pix_corr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    line_go,
    input  logic    tri_mode,
    input  colour_e mono_col,
    output ptag_t   tag_o,
    output logic    odd_o
);

    colour_e col_q;
    logic    odd_q;

    always_ff @(posedge clk) begin
        if (rst || !line_go) begin
            col_q <= COL_R;
            odd_q <= 1'b0;
            tag_o <= '0;
            odd_o <= 1'b0;
        end else begin
            tag_o.vld <= 1'b1;
            tag_o.col <= tri_mode ? col_q : mono_col;
            odd_o     <= odd_q;
            if (tri_mode) begin
                col_q <= col_after(col_q);
                if (col_q == COL_B) odd_q <= ~odd_q;
            end else begin
                odd_q <= ~odd_q;
            end
        end
    end

endmodule

// File: rtl/pix_corr_bus_dly.sv
module pix_corr_bus_dly #(
    parameter int W       = 8,
    parameter int DEPTH   = 6,
    parameter int TAP_TRI = 5,
    parameter int TAP_MON = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tri_mode,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [DEPTH-1:0][W-1:0] stage;

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stage[0] <= '0;
                else     stage[0] <= d;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) stage[k] <= '0;
                else     stage[k] <= stage[k-1];
            end
        end
    end

    assign q = tri_mode ? stage[TAP_TRI] : stage[TAP_MON];

endmodule

// File: rtl/pix_corr_dp.sv
module pix_corr_dp
    import pix_corr_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [DW-1:0]                   sample_in,
    input  ptag_t                           tag1,
    input  logic                            odd1,
    input  logic [OFS_REGS-1:0][REG_W-1:0]  ofs_tbl,
    input  logic [BUS_W-1:0]                ofs_now,
    input  logic [BUS_W-1:0]                gain_now,
    output logic [DW-1:0]                   pix_out,
    output ptag_t                           tag_out
);

    localparam int SW = DW + 2;
    localparam int PW = DW + BUS_W;
    localparam int RW = PW + 1;
    localparam logic [DW-1:0] MAXV = '1;

    logic [DW-1:0] s1_d, s2_d, s3_d, s5_d, s6_d;
    logic [PW-1:0] s4_d;
    ptag_t         t2, t3, t4, t5, t6;

    logic [REG_W-1:0]    off_sel;
    logic signed [SW-1:0] sum;
    logic [DW-1:0]       v_add, v_sub, v_sat;
    logic [DW:0]         diff;
    logic [PW-1:0]       prod;
    logic [RW-1:0]       rnd;

    // Stage 1: sample capture
    always_ff @(posedge clk) begin
        if (rst) s1_d <= '0;
        else     s1_d <= sample_in;
    end

    // Register offset chosen by colour and parity
    always_comb begin
        off_sel = '0;
        for (int k = 0; k < OFS_REGS; k++) begin
            if ({tag1.col, odd1} == ADDR_W'(k)) off_sel = ofs_tbl[k];
        end
    end

    always_comb begin
        sum = $signed({2'b00, s1_d}) + $signed({{(SW-REG_W){off_sel[REG_W-1]}}, off_sel});
        if (sum[SW-1])               v_add = '0;
        else if (sum[SW-2:DW] != '0) v_add = MAXV;
        else                         v_add = sum[DW-1:0];
    end

    always_comb begin
        diff  = {1'b0, s2_d} - (DW+1)'(ofs_now);
        v_sub = diff[DW] ? '0 : diff[DW-1:0];
    end

    assign prod = PW'(s3_d) * PW'(gain_now);

    always_comb begin
        rnd   = ({1'b0, s4_d} + RW'(1 << (RND_SH - 1))) >> RND_SH;
        v_sat = (rnd[RW-1:DW] != '0) ? MAXV : rnd[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_d <= '0; s3_d <= '0; s4_d <= '0; s5_d <= '0; s6_d <= '0;
            t2 <= '0; t3 <= '0; t4 <= '0; t5 <= '0; t6 <= '0;
        end else begin
            s2_d <= v_add;
            s3_d <= v_sub;
            s4_d <= prod;
            s5_d <= v_sat;
            s6_d <= t5.vld ? s5_d : '0;
            t2 <= tag1; t3 <= t2; t4 <= t3; t5 <= t4; t6 <= t5;
        end
    end

    assign pix_out = s6_d;
    assign tag_out = t6;

endmodule

// File: rtl/pix_corr_top.sv
module pix_corr_top
    import pix_corr_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_go,
    input  logic [DATA_W-1:0] sample_in,
    input  logic [7:0]        ofs_bus,
    input  logic [7:0]        gain_bus,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [DATA_W-1:0] pix_out,
    output logic              pix_vld,
    output logic [1:0]        pix_col
);

    logic [OFS_REGS-1:0][REG_W-1:0] ofs_tbl;
    logic                           tri_mode;
    colour_e                        mono_col;
    ptag_t                          tag1, tag_out;
    logic                           odd1;
    logic [BUS_W-1:0]               ofs_now, gain_now;

    pix_corr_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ofs_tbl(ofs_tbl), .tri_mode(tri_mode), .mono_col(mono_col)
    );

    pix_corr_seq u_seq (
        .clk(clk), .rst(rst), .line_go(line_go), .tri_mode(tri_mode),
        .mono_col(mono_col), .tag_o(tag1), .odd_o(odd1)
    );

    pix_corr_bus_dly #(
        .W(BUS_W), .DEPTH(OFS_TAP_TRI + 1),
        .TAP_TRI(OFS_TAP_TRI), .TAP_MON(OFS_TAP_MONO)
    ) u_ofs_dly (
        .clk(clk), .rst(rst), .tri_mode(tri_mode), .d(ofs_bus), .q(ofs_now)
    );

    pix_corr_bus_dly #(
        .W(BUS_W), .DEPTH(GAIN_TAP_TRI + 1),
        .TAP_TRI(GAIN_TAP_TRI), .TAP_MON(GAIN_TAP_MONO)
    ) u_gain_dly (
        .clk(clk), .rst(rst), .tri_mode(tri_mode), .d(gain_bus), .q(gain_now)
    );

    pix_corr_dp #(.DW(DATA_W)) u_dp (
        .clk(clk), .rst(rst), .sample_in(sample_in), .tag1(tag1), .odd1(odd1),
        .ofs_tbl(ofs_tbl), .ofs_now(ofs_now), .gain_now(gain_now),
        .pix_out(pix_out), .tag_out(tag_out)
    );

    assign pix_vld = tag_out.vld;
    assign pix_col = tag_out.col;

endmodule

// File: rtl/pix_corr_chk.sv
module pix_corr_chk (
    input logic       clk,
    input logic       rst,
    input logic       line_go,
    input logic       pix_vld,
    input logic [1:0] pix_col,
    input logic       tri_mode,
    input logic [1:0] mono_col
);

    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst < 3'd7) since_rst <= since_rst + 3'd1;
    end

    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd6) |-> (pix_vld == $past(line_go, 6)));

    p_seq_order_r2: assert property (@(posedge clk) disable iff (rst)
        (pix_vld && $past(pix_vld) && tri_mode) |->
        (pix_col == (($past(pix_col) == 2'd2) ? 2'd0 : $past(pix_col) + 2'd1)));

    p_line_first_red_r1: assert property (@(posedge clk) disable iff (rst)
        (pix_vld && !$past(pix_vld) && tri_mode) |-> (pix_col == 2'd0));

    p_mono_tag_r4: assert property (@(posedge clk) disable iff (rst)
        (pix_vld && !tri_mode) |-> (pix_col == mono_col));

endmodule

bind pix_corr_top pix_corr_chk u_chk (
    .clk(clk), .rst(rst), .line_go(line_go), .pix_vld(pix_vld),
    .pix_col(pix_col), .tri_mode(tri_mode), .mono_col(mono_col)
);

// File: tb/pix_corr_top_bench.sv
module pix_corr_top_bench;

    localparam int DW   = 12;
    localparam int MAXV = (1 << DW) - 1;
    localparam int NSEG = 60;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          line_go = 1'b0;
    logic [DW-1:0] sample_in = '0;
    logic [7:0]    ofs_bus = '0;
    logic [7:0]    gain_bus = '0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [DW-1:0] pix_out;
    logic          pix_vld;
    logic [1:0]    pix_col;

    always #4 clk = ~clk;

    pix_corr_top #(.DATA_W(DW)) u_pix_corr_top (
        .clk(clk), .rst(rst), .line_go(line_go), .sample_in(sample_in),
        .ofs_bus(ofs_bus), .gain_bus(gain_bus), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix_out(pix_out), .pix_vld(pix_vld), .pix_col(pix_col)
    );

    int n_chk = 0;
    int n_fail = 0;
    int m_ofs[6];
    int m_tri = 1;
    int m_sel = 0;
    int s_lg[NSEG], s_smp[NSEG], s_ofs[NSEG], s_gn[NSEG];
    int e_vld[NSEG], e_col[NSEG], e_val[NSEG];

    task automatic check(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 6) m_ofs[a] = (d > 127) ? d - 256 : d;
        else if (a == 6) begin m_tri = d & 1; m_sel = (d >> 6) & 3; end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < NSEG; i++) begin
            s_lg[i]  = !(i < 3 || i == 23 || i == 37 || i == 38 || i == 50);
            s_smp[i] = (i * 613 + seed * 97) % 4096;
            if (i % 11 == 0) s_smp[i] = MAXV;
            if (i % 13 == 0) s_smp[i] = 0;
            s_ofs[i] = (i * 53 + seed * 31) % 256;
            if (i % 5 == 0) s_ofs[i] = 0;
            s_gn[i]  = (i * 29 + seed * 7) % 256;
            if (i % 7 == 0)  s_gn[i] = 128;
            if (i % 17 == 0) s_gn[i] = 255;
            if (i % 19 == 0) s_gn[i] = 0;
        end
    endtask

    task automatic model();
        int col, odd, c, v;
        col = 0; odd = 0;
        for (int i = 0; i < NSEG; i++) begin
            if (s_lg[i] == 0) begin
                e_vld[i] = 0; e_col[i] = 0; e_val[i] = 0; col = 0; odd = 0;
            end else begin
                c = m_tri ? col : ((m_sel == 3) ? 2 : m_sel);
                v = s_smp[i] + m_ofs[c * 2 + odd];
                if (v < 0) v = 0;
                if (v > MAXV) v = MAXV;
                v = v - s_ofs[i];
                if (v < 0) v = 0;
                v = (v * s_gn[i] + 64) >> 7;
                if (v > MAXV) v = MAXV;
                e_vld[i] = 1; e_col[i] = c; e_val[i] = v;
                if (m_tri) begin
                    if (col == 2) begin col = 0; odd = 1 - odd; end
                    else col = col + 1;
                end else odd = 1 - odd;
            end
        end
    endtask

    task automatic run_seg(input int seed, input string lbl);
        int lead, j;
        fill(seed);
        model();
        lead = m_tri ? 3 : 1;
        for (int i = 0; i < NSEG + 6; i++) begin
            @(negedge clk);
            if (i >= 6) begin
                check({"R1 R7 valid ", lbl}, int'(pix_vld), e_vld[i-6]);
                if (e_vld[i-6] != 0) begin
                    check({"R2 R4 colour ", lbl}, int'(pix_col), e_col[i-6]);
                    check({"R3 R5 R6 R8 data ", lbl}, int'(pix_out), e_val[i-6]);
                end else begin
                    check({"R1 idle data ", lbl}, int'(pix_out), 0);
                end
            end
            if (i < NSEG) begin
                line_go = 1'(s_lg[i]); sample_in = DW'(s_smp[i]);
            end else begin
                line_go = 1'b0; sample_in = '0;
            end
            j = i + lead;
            ofs_bus  = (j < NSEG) ? 8'(s_ofs[j]) : 8'd0;
            gain_bus = (j < NSEG) ? 8'(s_gn[j]) : 8'd0;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 6; k++) m_ofs[k] = 0;
        repeat (3) @(negedge clk);
        check("R10 reset valid", int'(pix_vld), 0);
        check("R10 reset data", int'(pix_out), 0);
        rst = 1'b0;
        // R10: defaults, three-channel mode with zero offsets
        run_seg(6, "R10 defaults");
        wr(0, 5); wr(1, 8'hF9); wr(2, 60); wr(3, 8'hD8); wr(4, 8'h80); wr(5, 127);
        run_seg(1, "tri");
        wr(6, 8'h40);
        run_seg(2, "mono green");
        wr(6, 8'hC0);
        run_seg(3, "mono sel3 blue");
        wr(6, 8'h00);
        run_seg(4, "mono red");
        wr(6, 8'h01); wr(2, 8'h7F); wr(5, 8'h80);
        run_seg(5, "tri reprogrammed");
        // R9: address 7 must not disturb config or offsets
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd7; wr_data = 8'hFE;
        @(negedge clk);
        wr_en = 1'b0;
        run_seg(7, "R9 after addr7 write");
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 6; k++) m_ofs[k] = 0;
        m_tri = 1; m_sel = 0;
        run_seg(8, "R10 after reset");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule